// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches eight external interrupt pins and one non-maskable interrupt pin. Each pin is brought into the clock domain through a two-stage synchronizer. A history flop then lets the block detect a low level, a falling edge, a rising edge or either edge, depending on the sense mode programmed for that pin. A detected condition latches a request flag. Each flag drives its own interrupt output toward a downstream interrupt controller, which handles priority, masking and vectoring.

Software works through a simple register bus that carries 16-bit words and has a combinational read port. There are three registers. The non-maskable control/status word (byte offset 0) holds the synchronized pin level, the edge select and the request flag. The sense-select word (offset 2) holds a 2-bit mode per pin. The request word (offset 4) holds the eight IRQ flags. To clear a flag, software reads the register and then writes 0 to the bit it wants to clear, with 1 in every other bit. A clear only takes effect on a flag that the most recent read returned as 1. An event that arrives between the read and the write is therefore not lost.

Top module: `xint_sense_ctrl`

## Requirements
- R1: After reset all request flags are 0, every sense field is 0 and the non-maskable edge select is falling (0).
- R2: The sense field of IRQ n sits at bits [2n+1:2n] of offset 2 and reads back as written. Its encoding is 0 = low level, 1 = falling edge, 2 = rising edge, 3 = both edges.
- R3: In low-level mode a flag is set on every cycle that the synchronized pin is low. A clear attempt while the pin stays low leaves it set.
- R4: In the edge modes a flag is set only by the selected transition(s). The other transition leaves the flag at 0.
- R5: A flag and its output rise on the third rising clock edge after the pin changes: two synchronizer stages plus the flag register.
- R6: Offset 4 holds IRQ flags in bits [7:0]. Writing 0 clears a flag that the last read of offset 4 returned as 1. Bits written as 1 keep their value. Any write disarms all bits.
- R7: A write of 0 to a flag that was not read as 1 in the last read leaves the flag set. This includes an event that arrives after the read.
- R8: Bit 8 of offset 0 selects the non-maskable edge (0 = falling, 1 = rising). Bit 1 is its flag, and only the selected edge sets it.
- R9: The non-maskable flag clears under the same read-then-write-0 rule. Writing 1 to bit 1 never sets it.
- R10: Bit 15 of offset 0 is read-only and shows the synchronized non-maskable pin level two clock edges after the pin changes.
- R11: irq_out[n] equals IRQ flag n and nmi_out equals the non-maskable flag.
- R12: Unused bits of the mapped registers, and every unmapped offset, read as 0. A set event takes priority over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| irq_pin | input | 8 | External interrupt pins |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| irq_out | output | 8 | Per-pin interrupt requests |
| nmi_out | output | 1 | Non-maskable interrupt request |

## Verification
A pin change is driven just after a falling clock edge. Its flag is due after exactly three rising edges, and the level readback is due after two. The bench counts those edges and samples 1 ns after the due edge. One check samples the flag one edge early and expects 0, which pins down the latency from both sides. A register write takes effect at the rising edge inside its bus cycle, so outputs are checked after the following falling edge. Reads are sampled in the same cycle because the read port is combinational.

// File: rtl/xint_pkg.sv
package xint_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } sense_mode_e;

  localparam int OFS_NMI_CTL = 0;
  localparam int OFS_SENSE   = 2;
  localparam int OFS_REQ     = 4;

  localparam int NMI_FLAG_BIT  = 1;
  localparam int NMI_EDGE_BIT  = 8;
  localparam int NMI_LEVEL_BIT = 15;
endpackage

// File: rtl/xint_pin_sync.sv
module xint_pin_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] lvl_prev_o
);
  logic [W-1:0] stage1;

  // Reset to the idle-high level so no edge appears out of reset.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1     <= '1;
      lvl_o      <= '1;
      lvl_prev_o <= '1;
    end else begin
      stage1     <= pin_i;
      lvl_o      <= stage1;
      lvl_prev_o <= lvl_o;
    end
  end
endmodule

// File: rtl/xint_edge_sense.sv
module xint_edge_sense
  import xint_pkg::*;
(
  input  sense_mode_e mode_i,
  input  logic        cur_i,
  input  logic        prev_i,
  output logic        hit_o
);
  always_comb begin
    unique case (mode_i)
      SENSE_LOW:  hit_o = ~cur_i;
      SENSE_FALL: hit_o = prev_i & ~cur_i;
      SENSE_RISE: hit_o = ~prev_i & cur_i;
      SENSE_BOTH: hit_o = prev_i ^ cur_i;
      default:    hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/xint_req_flags.sv
module xint_req_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [W-1:0] keep_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] armed;
  logic [W-1:0] clr;

  assign clr = armed & ~keep_i & {W{wr_i}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o <= '0;
      armed  <= '0;
    end else begin
      // a new event wins over a clear in the same cycle
      flag_o <= set_i | (flag_o & ~clr);
      if (rd_i)
        armed <= flag_o;
      else if (wr_i)
        armed <= '0;
    end
  end
endmodule

// File: rtl/xint_sense_ctrl.sv
module xint_sense_ctrl
  import xint_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_pin,
  input  logic               nmi_pin,
  output logic [NUM_IRQ-1:0] irq_out,
  output logic               nmi_out
);
  localparam int NPIN    = NUM_IRQ + 1;
  localparam int SENSE_W = 2 * NUM_IRQ;

  logic [NPIN-1:0]    lvl, lvl_prev;
  logic [NPIN-1:0]    hit;
  logic [SENSE_W-1:0] sense_q;
  logic               nmi_rise_q;
  logic [NUM_IRQ-1:0] irq_flags;
  logic [0:0]         nmi_flag;
  logic               rd, wr, sel_ctl, sel_sense, sel_req;

  assign rd        = bus_sel & ~bus_wr;
  assign wr        = bus_sel & bus_wr;
  assign sel_ctl   = (bus_addr == ADDR_W'(OFS_NMI_CTL));
  assign sel_sense = (bus_addr == ADDR_W'(OFS_SENSE));
  assign sel_req   = (bus_addr == ADDR_W'(OFS_REQ));

  xint_pin_sync #(.W(NPIN)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      ({nmi_pin, irq_pin}),
    .lvl_o      (lvl),
    .lvl_prev_o (lvl_prev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sense_q    <= '0;
      nmi_rise_q <= 1'b0;
    end else begin
      if (wr && sel_sense) sense_q    <= bus_wdata[SENSE_W-1:0];
      if (wr && sel_ctl)   nmi_rise_q <= bus_wdata[NMI_EDGE_BIT];
    end
  end

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_irq
    xint_edge_sense u_det (
      .mode_i (sense_mode_e'(sense_q[2*n +: 2])),
      .cur_i  (lvl[n]),
      .prev_i (lvl_prev[n]),
      .hit_o  (hit[n])
    );
  end

  xint_edge_sense u_nmi_det (
    .mode_i (nmi_rise_q ? SENSE_RISE : SENSE_FALL),
    .cur_i  (lvl[NUM_IRQ]),
    .prev_i (lvl_prev[NUM_IRQ]),
    .hit_o  (hit[NUM_IRQ])
  );

  xint_req_flags #(.W(NUM_IRQ)) u_irq_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (hit[NUM_IRQ-1:0]),
    .rd_i   (rd && sel_req),
    .wr_i   (wr && sel_req),
    .keep_i (bus_wdata[NUM_IRQ-1:0]),
    .flag_o (irq_flags)
  );

  xint_req_flags #(.W(1)) u_nmi_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (hit[NUM_IRQ +: 1]),
    .rd_i   (rd && sel_ctl),
    .wr_i   (wr && sel_ctl),
    .keep_i (bus_wdata[NMI_FLAG_BIT +: 1]),
    .flag_o (nmi_flag)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_ctl) begin
      bus_rdata[NMI_LEVEL_BIT] = lvl[NUM_IRQ];
      bus_rdata[NMI_EDGE_BIT]  = nmi_rise_q;
      bus_rdata[NMI_FLAG_BIT]  = nmi_flag[0];
    end else if (sel_sense) begin
      bus_rdata[SENSE_W-1:0] = sense_q;
    end else if (sel_req) begin
      bus_rdata[NUM_IRQ-1:0] = irq_flags;
    end
  end

  assign irq_out = irq_flags;
  assign nmi_out = nmi_flag[0];
endmodule

// File: rtl/xint_sense_chk.sv
module xint_sense_chk #(
  parameter int NUM_IRQ = 8,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [NUM_IRQ-1:0]   irq_out,
  input logic                 nmi_out,
  input logic [2*NUM_IRQ-1:0] sense_cfg,
  input logic [NUM_IRQ:0]     lvl
);
  assert_irq_drop_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(irq_out) & ~irq_out)) |->
      $past(bus_sel && bus_wr && bus_addr == ADDR_W'(4)));

  assert_nmi_drop_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_out) |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'(0)));

  assert_req_upper_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(4)) |-> (bus_rdata[DATA_W-1:NUM_IRQ] == '0));

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != ADDR_W'(0) && bus_addr != ADDR_W'(2) && bus_addr != ADDR_W'(4))
      |-> (bus_rdata == '0));

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_pin
    assert_low_level_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_cfg[2*n +: 2] == 2'd0 && !lvl[n]) |=> irq_out[n]);

    assert_rise_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_cfg[2*n +: 2] == 2'd2 && lvl[n] && !$past(lvl[n])) |=> irq_out[n]);
  end
endmodule

bind xint_sense_ctrl xint_sense_chk #(
  .NUM_IRQ (NUM_IRQ),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .nmi_out   (nmi_out),
  .sense_cfg (sense_q),
  .lvl       (lvl)
);

// File: tb/xint_sense_ctrl_test.sv
module xint_sense_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  irq_pin = 8'hFF;
  logic        nmi_pin = 1'b1;
  logic [7:0]  irq_out;
  logic        nmi_out;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  xint_sense_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pin(irq_pin), .nmi_pin(nmi_pin), .irq_out(irq_out), .nmi_out(nmi_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic clear_irqs();
    logic [15:0] d;
    rd_reg(3'd4, d);
    wr_reg(3'd4, 16'h0000);
  endtask

  task automatic set_pin(input int n, input logic v);
    @(negedge clk);
    irq_pin[n] = v;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd_reg(3'd0, d); check("R1 ctl0", d, 16'h8000);
    rd_reg(3'd2, d); check("R1 sense", d, 16'h0000);
    rd_reg(3'd4, d); check("R1 flags", d, 16'h0000);
    check("R1 outputs", {7'd0, nmi_out, irq_out}, 16'h0000);

    // R2 readback of all sense fields, R12 unmapped offsets
    wr_reg(3'd2, 16'hE41B); rd_reg(3'd2, d); check("R2 readback", d, 16'hE41B);
    wr_reg(3'd2, 16'h0000);
    for (int a = 1; a < 8; a++) begin
      if (a != 2 && a != 4) begin
        rd_reg(3'(a), d); check("R12 unmapped", d, 16'h0000);
      end
    end

    // R5 latency: fall mode on pin 0
    wr_reg(3'd2, 16'h0001);
    @(negedge clk); irq_pin[0] = 1'b0;
    repeat (2) @(posedge clk); #1;
    check("R5 early", {8'd0, irq_out}, 16'h0000);
    @(posedge clk); #1;
    check("R5 due", {8'd0, irq_out}, 16'h0001);
    set_pin(0, 1'b1);
    clear_irqs();

    // R2 R3 R4 R6 R11 sweep over every mode and pin
    for (int m = 0; m < 4; m++) begin
      for (int n = 0; n < 8; n++) begin
        logic [7:0] bit_n;
        bit_n = 8'(1 << n);
        wr_reg(3'd2, 16'(m << (2 * n)));
        clear_irqs();
        check("R6 cleared before", {8'd0, irq_out}, 16'h0000);
        set_pin(n, 1'b0);
        check("R4 R3 after fall", {8'd0, irq_out}, {8'd0, (m != 2) ? bit_n : 8'h00});
        rd_reg(3'd4, d);
        check("R11 flags equal outputs", d, {8'd0, irq_out});
        wr_reg(3'd4, 16'h0000);
        check("R3 clear while low", {8'd0, irq_out}, {8'd0, (m == 0) ? bit_n : 8'h00});
        set_pin(n, 1'b1);
        check("R4 after rise", {8'd0, irq_out}, {8'd0, (m != 1) ? bit_n : 8'h00});
        clear_irqs();
        check("R6 clear after rise", {8'd0, irq_out}, 16'h0000);
      end
    end

    // R6 keep bits written as 1
    wr_reg(3'd2, 16'h1004);
    @(negedge clk); irq_pin[1] = 1'b0; irq_pin[6] = 1'b0;
    repeat (3) @(posedge clk);
    rd_reg(3'd4, d); check("R6 two flags", d, 16'h0042);
    wr_reg(3'd4, 16'hFFFD);
    rd_reg(3'd4, d); check("R6 only target cleared", d, 16'h0040);
    @(negedge clk); irq_pin[1] = 1'b1; irq_pin[6] = 1'b1;
    clear_irqs();

    // R7 write 0 without a read showing 1
    wr_reg(3'd2, 16'h0440);
    set_pin(3, 1'b0);
    wr_reg(3'd4, 16'h0000);
    check("R7 unread kept", {8'd0, irq_out}, 16'h0008);
    rd_reg(3'd4, d);
    set_pin(5, 1'b0);
    wr_reg(3'd4, 16'h0000);
    check("R7 late event kept", {8'd0, irq_out}, 16'h0020);
    @(negedge clk); irq_pin[3] = 1'b1; irq_pin[5] = 1'b1;
    clear_irqs();
    check("R6 final clear", {8'd0, irq_out}, 16'h0000);
    wr_reg(3'd2, 16'h0000);

    // R8 R10 R11 non-maskable, falling select
    @(negedge clk); nmi_pin = 1'b0;
    repeat (2) @(posedge clk);
    rd_reg(3'd0, d); check("R10 level low, flag pending", d, 16'h0000);
    check("R8 falling sets", {15'd0, nmi_out}, 16'h0001);
    wr_reg(3'd0, 16'h0000);
    check("R9 unread kept", {15'd0, nmi_out}, 16'h0001);
    rd_reg(3'd0, d); check("R8 flag bit", d, 16'h0002);
    wr_reg(3'd0, 16'h0000);
    check("R9 cleared", {15'd0, nmi_out}, 16'h0000);
    wr_reg(3'd0, 16'h0102);
    rd_reg(3'd0, d); check("R9 write one no set", d, 16'h0100);
    @(negedge clk); nmi_pin = 1'b1;
    repeat (3) @(posedge clk); #1;
    check("R8 rising sets", {15'd0, nmi_out}, 16'h0001);
    rd_reg(3'd0, d); check("R10 level high", d, 16'h8102);
    wr_reg(3'd0, 16'h0100);
    check("R9 cleared again", {15'd0, nmi_out}, 16'h0000);
    @(negedge clk); nmi_pin = 1'b0;
    repeat (3) @(posedge clk); #1;
    check("R8 falling ignored", {15'd0, nmi_out}, 16'h0000);
    rd_reg(3'd0, d); check("R12 ctl0 unused bits", d, 16'h0100);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule